// File: doc/BRIEF.md
# Pipeline hazard control unit

This block is a purely combinational controller for a five-stage in-order pipeline with the stages fetch, decode, execute, memory and writeback. It decides when the front end must hold and when it must discard work. It looks at three things: the source register fields and format code of the instruction in decode, the destination and load flag of the instruction in execute, and a redirect request raised by the memory stage for a taken branch or a jump.

From these inputs it drives the PC write enable and the next PC value. It also drives the write enable of the fetch/decode register and the clear controls of the fetch/decode, decode/execute and execute/memory stage registers. When a stage register is cleared, it holds all zeros. The datapath reads that value as a no-op with every write enable off.

A load-use conflict holds the PC and the fetch/decode register and inserts one bubble into decode/execute. A redirect loads the target into the PC and clears all three stage registers in the same cycle.

Top module: `hz_ctrl_unit`

## Requirements
- R1: When `ex_load_i` is 1, `ex_rd_i` is nonzero, `mem_redir_i` is 0, and a source that decode reads equals `ex_rd_i`, the outputs are `pc_we_o`=0, `ifid_we_o`=0 and `idex_flush_o`=1, all in the same cycle.
- R2: Format codes are 0=R, 1=I, 2=S, 3=SB, 4=U and 5=UJ; codes 6 and 7 read no sources. `id_rs2_i` is compared only for codes 0, 2 and 3, and `id_rs1_i` only for codes 0 to 3.
- R3: Codes 4 (U) and 5 (UJ) never cause a stall, even when both register fields equal the load destination.
- R4: A load whose destination is 0 never causes a stall.
- R5: When `mem_redir_i` is 1, `pc_we_o`=1, `pc_next_o`=`mem_target_i`, and `ifid_flush_o`, `idex_flush_o` and `exmem_flush_o` are all 1.
- R6: When a redirect and a load-use conflict occur in the same cycle, the redirect decides every output. `ifid_we_o` stays 1 and the clear takes effect.
- R7: With no conflict and no redirect, `pc_we_o`=1, `ifid_we_o`=1, all clears are 0, and `pc_next_o`=`pc_seq_i`.
- R8: A stall alone never raises `ifid_flush_o` or `exmem_flush_o`. After the clock edge, the fetch/decode register keeps its value and execute/memory receives the previous decode/execute contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_AW | First source field of the decode instruction |
| id_rs2_i | input | REG_AW | Second source field of the decode instruction |
| id_fmt_i | input | 3 | Format code of the decode instruction |
| ex_rd_i | input | REG_AW | Destination field of the execute instruction |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_redir_i | input | 1 | Taken branch or jump in memory stage |
| mem_target_i | input | ADDR_W | Redirect target address |
| pc_seq_i | input | ADDR_W | Sequential next PC |
| pc_we_o | output | 1 | PC write enable |
| pc_next_o | output | ADDR_W | Value loaded into the PC |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| ifid_flush_o | output | 1 | Clear fetch/decode register |
| idex_flush_o | output | 1 | Clear decode/execute register |
| exmem_flush_o | output | 1 | Clear execute/memory register |

## Verification
Every control output is combinational, so each output is due in the same cycle as its stimulus. The bench drives the inputs on the falling edge and compares the outputs 1 ns later, before the next rising edge. The effect on the stage registers modelled in the bench is due one rising edge later. Those registers are compared 1 ns after that edge, against a behavioural prediction taken from the previous register contents.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [2:0] {
    FMT_R  = 3'd0,
    FMT_I  = 3'd1,
    FMT_S  = 3'd2,
    FMT_SB = 3'd3,
    FMT_U  = 3'd4,
    FMT_UJ = 3'd5,
    FMT_X6 = 3'd6,
    FMT_X7 = 3'd7
  } fmt_e;

  localparam int unsigned NSRC = 2;
endpackage

// File: rtl/hz_src_use.sv
module hz_src_use
  import hz_pkg::*;
(
  input  logic [2:0]      fmt_i,
  output logic [NSRC-1:0] use_o
);
  fmt_e fmt;
  assign fmt = fmt_e'(fmt_i);

  always_comb begin
    unique case (fmt)
      FMT_R, FMT_S, FMT_SB: use_o = 2'b11;
      FMT_I:                use_o = 2'b01;
      default:              use_o = 2'b00; // U, UJ, reserved: no sources
    endcase
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [NSRC-1:0][REG_AW-1:0] src_i,
  input  logic [NSRC-1:0]             use_i,
  input  logic [REG_AW-1:0]           ex_rd_i,
  input  logic                        ex_load_i,
  output logic                        stall_o
);
  logic [NSRC-1:0] hit;
  logic            rd_live;

  assign rd_live = ex_load_i && (ex_rd_i != '0);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit[s] = use_i[s] && (src_i[s] != '0) && (src_i[s] == ex_rd_i);
  end

  assign stall_o = rd_live && (|hit);
endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter (
  input  logic stall_i,
  input  logic redir_i,
  output logic pc_we_o,
  output logic pc_sel_tgt_o,
  output logic ifid_we_o,
  output logic ifid_flush_o,
  output logic idex_flush_o,
  output logic exmem_flush_o
);
  always_comb begin
    pc_we_o       = 1'b1;
    pc_sel_tgt_o  = 1'b0;
    ifid_we_o     = 1'b1;
    ifid_flush_o  = 1'b0;
    idex_flush_o  = 1'b0;
    exmem_flush_o = 1'b0;
    if (redir_i) begin
      // redirect dominates any pending stall
      pc_sel_tgt_o  = 1'b1;
      ifid_flush_o  = 1'b1;
      idex_flush_o  = 1'b1;
      exmem_flush_o = 1'b1;
    end else if (stall_i) begin
      pc_we_o      = 1'b0;
      ifid_we_o    = 1'b0;
      idex_flush_o = 1'b1;
    end
  end
endmodule

// File: rtl/hz_ctrl_unit.sv
module hz_ctrl_unit
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned ADDR_W = 32
) (
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic [2:0]        id_fmt_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_load_i,
  input  logic              mem_redir_i,
  input  logic [ADDR_W-1:0] mem_target_i,
  input  logic [ADDR_W-1:0] pc_seq_i,
  output logic              pc_we_o,
  output logic [ADDR_W-1:0] pc_next_o,
  output logic              ifid_we_o,
  output logic              ifid_flush_o,
  output logic              idex_flush_o,
  output logic              exmem_flush_o
);
  logic [NSRC-1:0]             src_use;
  logic [NSRC-1:0][REG_AW-1:0] src_vec;
  logic                        stall;
  logic                        pc_sel_tgt;

  assign src_vec[0] = id_rs1_i;
  assign src_vec[1] = id_rs2_i;

  hz_src_use u_src_use (
    .fmt_i (id_fmt_i),
    .use_o (src_use)
  );

  hz_load_use #(.REG_AW(REG_AW)) u_load_use (
    .src_i     (src_vec),
    .use_i     (src_use),
    .ex_rd_i   (ex_rd_i),
    .ex_load_i (ex_load_i),
    .stall_o   (stall)
  );

  hz_arbiter u_arb (
    .stall_i       (stall),
    .redir_i       (mem_redir_i),
    .pc_we_o       (pc_we_o),
    .pc_sel_tgt_o  (pc_sel_tgt),
    .ifid_we_o     (ifid_we_o),
    .ifid_flush_o  (ifid_flush_o),
    .idex_flush_o  (idex_flush_o),
    .exmem_flush_o (exmem_flush_o)
  );

  assign pc_next_o = pc_sel_tgt ? mem_target_i : pc_seq_i;

  always_comb begin
    // R5
    redir_flush_chk: assert (!mem_redir_i ||
      (pc_we_o && ifid_flush_o && idex_flush_o && exmem_flush_o && pc_next_o == mem_target_i));
    // R1
    stall_hold_chk: assert (!(stall && !mem_redir_i) ||
      (!pc_we_o && !ifid_we_o && idex_flush_o));
    // R3
    u_no_stall_chk: assert (!(id_fmt_i == 3'd4 || id_fmt_i == 3'd5) || !stall);
    // R4
    x0_no_stall_chk: assert (ex_rd_i != '0 || !stall);
    // R8
    stall_scope_chk: assert (mem_redir_i || (!ifid_flush_o && !exmem_flush_o));
    // R6
    redir_we_chk: assert (!mem_redir_i || ifid_we_o);
  end
endmodule

// File: tb/hz_ctrl_unit_tb_top.sv
module hz_ctrl_unit_tb_top;
  localparam int unsigned AW = 5;
  localparam int unsigned XW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] rs1, rs2, rd;
  logic [2:0]    fmt;
  logic          ld, redir;
  logic [XW-1:0] tgt, pcs, pc_next;
  logic          pc_we, ifid_we, ifid_fl, idex_fl, exmem_fl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hz_ctrl_unit #(.REG_AW(AW), .ADDR_W(XW)) dut_i (
    .id_rs1_i(rs1), .id_rs2_i(rs2), .id_fmt_i(fmt), .ex_rd_i(rd),
    .ex_load_i(ld), .mem_redir_i(redir), .mem_target_i(tgt), .pc_seq_i(pcs),
    .pc_we_o(pc_we), .pc_next_o(pc_next), .ifid_we_o(ifid_we),
    .ifid_flush_o(ifid_fl), .idex_flush_o(idex_fl), .exmem_flush_o(exmem_fl)
  );

  // stage register model driven by the DUT controls
  logic [31:0] fetch_tok, ifid_q, idex_q, exmem_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_tok <= 32'd1;
      ifid_q <= '0; idex_q <= '0; exmem_q <= '0;
    end else begin
      fetch_tok <= pc_we ? fetch_tok + 32'd1 : fetch_tok;
      ifid_q    <= ifid_fl ? '0 : (ifid_we ? fetch_tok : ifid_q);
      idex_q    <= idex_fl ? '0 : ifid_q;
      exmem_q   <= exmem_fl ? '0 : idex_q;
    end
  end

  function automatic logic [4:0] ref_ctl(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                         input logic [2:0] f, input logic [AW-1:0] d,
                                         input logic l, input logic r);
    bit reads_a, reads_b, conflict;
    reads_a = (f <= 3'd3);
    reads_b = (f == 3'd0) || (f == 3'd2) || (f == 3'd3);
    conflict = l && d != 0 && ((reads_a && a == d) || (reads_b && b == d));
    if (r)             return 5'b11111; // pc_we ifid_we ifid_fl idex_fl exmem_fl
    else if (conflict) return 5'b00010;
    else               return 5'b11000;
  endfunction

  task automatic step(input string req, input logic [AW-1:0] a, input logic [AW-1:0] b,
                      input logic [2:0] f, input logic [AW-1:0] d, input logic l,
                      input logic r, input logic [XW-1:0] t);
    logic [4:0]  exp_c, got_c;
    logic [XW-1:0] exp_pc;
    logic [31:0] e_tok, e_ifid, e_idex, e_exmem;
    @(negedge clk);
    rs1 = a; rs2 = b; fmt = f; rd = d; ld = l; redir = r; tgt = t;
    pcs = 32'h0000_1000 + {fetch_tok[29:0], 2'b00};
    #1;
    exp_c  = ref_ctl(a, b, f, d, l, r);
    exp_pc = r ? t : pcs;
    got_c  = {pc_we, ifid_we, ifid_fl, idex_fl, exmem_fl};
    checks++;
    if (got_c !== exp_c || pc_next !== exp_pc) begin
      errors++;
      $display("FAIL %s ctl=%b pc=%h expected ctl=%b pc=%h", req, got_c, pc_next, exp_c, exp_pc);
    end
    e_tok   = exp_c[4] ? fetch_tok + 1 : fetch_tok;
    e_ifid  = exp_c[2] ? 32'd0 : (exp_c[3] ? fetch_tok : ifid_q);
    e_idex  = exp_c[1] ? 32'd0 : ifid_q;
    e_exmem = exp_c[0] ? 32'd0 : idex_q;
    @(posedge clk);
    #1;
    checks++;
    if ({fetch_tok, ifid_q, idex_q, exmem_q} !== {e_tok, e_ifid, e_idex, e_exmem}) begin
      errors++;
      $display("FAIL %s stages=%h/%h/%h/%h expected %h/%h/%h/%h", req,
               fetch_tok, ifid_q, idex_q, exmem_q, e_tok, e_ifid, e_idex, e_exmem);
    end
  endtask

  initial begin
    rs1 = '0; rs2 = '0; fmt = '0; rd = '0; ld = 0; redir = 0; tgt = '0; pcs = '0;
    #12;
    // reset state of the stage model
    checks++;
    if ({ifid_q, idex_q, exmem_q} !== '0 || fetch_tok !== 32'd1) begin
      errors++;
      $display("FAIL R7 reset stages=%h/%h/%h expected zero", ifid_q, idex_q, exmem_q);
    end
    rst_ni = 1'b1;
    step("R7", 5'd1, 5'd2, 3'd0, 5'd3, 1'b0, 1'b0, 32'h0);
    step("R7", 5'd4, 5'd5, 3'd0, 5'd4, 1'b0, 1'b0, 32'h0);   // match but not a load
    step("R1", 5'd7, 5'd9, 3'd0, 5'd7, 1'b1, 1'b0, 32'h0);   // R rs1 hit
    step("R8", 5'd3, 5'd9, 3'd2, 5'd9, 1'b1, 1'b0, 32'h0);   // S rs2 hit, stage effect
    step("R2", 5'd3, 5'd9, 3'd1, 5'd9, 1'b1, 1'b0, 32'h0);   // I ignores rs2
    step("R2", 5'd9, 5'd3, 3'd1, 5'd9, 1'b1, 1'b0, 32'h0);   // I rs1 hit
    step("R2", 5'd1, 5'd8, 3'd3, 5'd8, 1'b1, 1'b0, 32'h0);   // SB rs2 hit
    step("R2", 5'd8, 5'd8, 3'd6, 5'd8, 1'b1, 1'b0, 32'h0);   // reserved code reads none
    step("R3", 5'd6, 5'd6, 3'd4, 5'd6, 1'b1, 1'b0, 32'h0);   // U
    step("R3", 5'd6, 5'd6, 3'd5, 5'd6, 1'b1, 1'b0, 32'h0);   // UJ
    step("R4", 5'd0, 5'd0, 3'd0, 5'd0, 1'b1, 1'b0, 32'h0);   // load to x0
    step("R7", 5'd0, 5'd2, 3'd1, 5'd0, 1'b0, 1'b0, 32'h0);
    step("R5", 5'd1, 5'd2, 3'd0, 5'd3, 1'b0, 1'b1, 32'h0000_2040);
    step("R7", 5'd1, 5'd2, 3'd0, 5'd3, 1'b0, 1'b0, 32'h0);
    step("R6", 5'd5, 5'd2, 3'd0, 5'd5, 1'b1, 1'b1, 32'h0000_3000);
    step("R1", 5'd2, 5'd11, 3'd3, 5'd11, 1'b1, 1'b0, 32'h0);
    step("R1", 5'd2, 5'd11, 3'd3, 5'd11, 1'b1, 1'b0, 32'h0); // back-to-back stall
    step("R7", 5'd2, 5'd11, 3'd3, 5'd12, 1'b1, 1'b0, 32'h0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule